// File: doc/BRIEF.md
# Bank-Armed Line Change Interrupt Unit

This block watches 32 already-synchronized input lines and raises one interrupt request when a line changes in a direction software has armed. The lines form four banks of eight: banks 0, 1 and 2 hold the isolated inputs 0-7, 8-15 and 16-23, and bank 3 holds the eight shared lines. An 8-bit arming register, written over a byte-wide register bus, selects rising detection and falling detection independently for each bank, not for each line.

A line that makes an armed transition latches a sticky flag. The 32 flags read back as four bytes at consecutive addresses, which together form one 32-bit word with line k at bit k. Software clears flags by writing ones to the byte that holds them. The request output stays high while any flag is set, and its level can also be read over the bus.

Bus map: address 0 to 3 hold status bytes 0 to 3 (read the flags, write ones to clear). Address 4 holds the arming register (read and write). Address 5 reads the request level in bit 0 and ignores writes. Other addresses read zero. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `line_event_irq`

## Requirements
- R1: Arming bit n (n = 0..3) enables rising-edge detection for bank n. A 0-to-1 change on a line of an unarmed bank sets no flag.
- R2: Arming bit n+4 enables falling-edge detection for bank n. A 1-to-0 change on a line of an unarmed bank sets no flag.
- R3: Line k belongs to bank k/8 and sets status bit k. That bit is bit k%8 of the status byte at address k/8.
- R4: A flag stays set until it is cleared, even after the line returns to its earlier level.
- R5: Writing a byte to status address a clears exactly the flags at the positions written as 1 in that byte. Zeros, and writes to other addresses, leave those flags unchanged.
- R6: When an armed edge and a clear hit the same flag in the same cycle, the flag remains set.
- R7: Clearing an arming bit does not clear flags that are already set.
- R8: irq_o is high exactly while at least one flag is set. Bit 0 of address 5 reads the same level.
- R9: Reset clears all flags and the arming register. A line level held through reset causes no flag afterwards.
- R10: The arming register reads back at address 4 with the value last written.
- R11: An edge is a difference between a line's value and its value one clock earlier. The flag is visible on the bus and on irq_o right after the clock edge that samples the changed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 32 | Synchronized line values, line k at bit k |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe for the current address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current address |
| irq_o | output | 1 | Interrupt request, high while any flag is set |

## Verification
The assertions assume that line_i is already synchronous to clk and changes only between clock edges. They also assume that reset is held low for at least two clock edges, so the one-cycle history they compare against is defined. The bench changes the lines and bus inputs only on the falling clock edge and holds reset for several cycles. Its random phase flips only a few line bits per cycle and interleaves bus writes to every address, including the unmapped ones, so that all inputs stay inside those assumptions.

// File: rtl/lev_pkg.sv
// Package: shared widths and the bus register map of the line event unit.
// Assumes the register bus is one byte wide and each bank is one byte of lines.
package lev_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Address of the arming register for a given bank count
    function automatic int arm_addr(input int nbank);
        return nbank;
    endfunction

    // Address of the request-level readback for a given bank count
    function automatic int pin_addr(input int nbank);
        return nbank + 1;
    endfunction
endpackage

// File: rtl/lev_edge.sv
// Module: per-line edge detector with bank-wide arming.
// Compares each line with its value one clock earlier. A bank's rising arm bit
// (arm_i[b]) and falling arm bit (arm_i[b+NBANK]) gate the hits of its lines.
// Assumes line_i is synchronous to clk.
module lev_edge #(
    parameter int NBANK = 4,
    localparam int BW    = lev_pkg::BYTE_W,
    localparam int NLINE = NBANK * BW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLINE-1:0] line_i,
    input  logic [2*NBANK-1:0] arm_i,
    output logic [NLINE-1:0] hit_o
);
    logic [NLINE-1:0] prev_q;

    // Hold the previous line values; reset captures the present level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= line_i;
        else        prev_q <= line_i;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [BW-1:0] cur, old, rise, fall;
        // Split the bank's slice and qualify each direction by its arm bit
        always_comb begin
            cur  = line_i[b*BW +: BW];
            old  = prev_q[b*BW +: BW];
            rise = cur & ~old & {BW{arm_i[b]}};
            fall = ~cur & old & {BW{arm_i[b+NBANK]}};
            hit_o[b*BW +: BW] = rise | fall;
        end

        // R1
        rise_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((hit_o[b*BW +: BW] & line_i[b*BW +: BW]) != '0) |-> arm_i[b]);
        // R2
        fall_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((hit_o[b*BW +: BW] & ~line_i[b*BW +: BW]) != '0) |-> arm_i[b+NBANK]);
    end

    for (genvar k = 0; k < NLINE; k++) begin : g_line
        // R11
        edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o[k] |-> (line_i[k] != $past(line_i[k])));
    end
endmodule

// File: rtl/lev_status.sv
// Module: sticky event flags with write-one-to-clear.
// A hit sets its flag and a clear bit drops it; a hit in the same cycle wins.
// Assumes hit_i and clr_i are valid one cycle before the edge that applies them.
module lev_status #(
    parameter int NLINE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLINE-1:0] hit_i,
    input  logic [NLINE-1:0] clr_i,
    output logic [NLINE-1:0] st_o
);
    logic [NLINE-1:0] st_q;

    // Update flags: keep uncleared bits, then add new hits
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_i) | hit_i;
    end

    assign st_o = st_q;

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(st_q & ~clr_i)) == $past(st_q & ~clr_i)));
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(hit_i)) == $past(hit_i)));
    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & ~$past(st_q) & ~$past(hit_i)) == '0));
endmodule

// File: rtl/lev_regif.sv
// Module: byte bus decode for the line event unit.
// Holds the arming register, turns status writes into clear masks and
// multiplexes read data. Assumes one access per cycle; reads are combinational.
module lev_regif #(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 3,
    localparam int BW    = lev_pkg::BYTE_W,
    localparam int NLINE = NBANK * BW,
    localparam int AARM  = lev_pkg::arm_addr(NBANK),
    localparam int APIN  = lev_pkg::pin_addr(NBANK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic [BW-1:0]      wdata_i,
    input  logic [NLINE-1:0]   st_i,
    input  logic               irq_i,
    output logic [2*NBANK-1:0] arm_o,
    output logic [NLINE-1:0]   clr_o,
    output logic [BW-1:0]      rdata_o
);
    logic [2*NBANK-1:0] arm_q;

    // Arming register: written at its address, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_q <= '0;
        else if (wr_i && addr_i == ADDR_W'(AARM))
            arm_q <= wdata_i[2*NBANK-1:0];
    end

    assign arm_o = arm_q;

    // Clear mask: a status write places its byte at its bank position
    always_comb begin
        clr_o = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (wr_i && addr_i == ADDR_W'(b))
                clr_o[b*BW +: BW] = wdata_i;
        end
    end

    // Read multiplexer over status bytes, arming register and request level
    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (addr_i == ADDR_W'(b))
                rdata_o = st_i[b*BW +: BW];
        end
        if (addr_i == ADDR_W'(AARM))
            rdata_o = BW'(arm_q);
        if (addr_i == ADDR_W'(APIN))
            rdata_o = {{(BW-1){1'b0}}, irq_i};
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (arm_q == '0));
    // R10
    arm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(AARM)) |=> (arm_q == $past(wdata_i[2*NBANK-1:0])));
endmodule

// File: rtl/line_event_irq.sv
// Module: top of the bank-armed line change interrupt unit.
// Joins the edge detector, the sticky flags and the bus decode, and drives one
// level request from the flags. Assumes synchronized lines and a synchronous
// active-low reset held for at least two edges.
module line_event_irq #(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 3,
    localparam int BW    = lev_pkg::BYTE_W,
    localparam int NLINE = NBANK * BW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINE-1:0]  line_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [BW-1:0]     bus_wdata_i,
    output logic [BW-1:0]     bus_rdata_o,
    output logic              irq_o
);
    logic [2*NBANK-1:0] arm;
    logic [NLINE-1:0]   hit, clr, st;

    lev_edge #(.NBANK(NBANK)) u_edge (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .arm_i(arm), .hit_o(hit)
    );

    lev_status #(.NLINE(NLINE)) u_status (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(clr), .st_o(st)
    );

    lev_regif #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_regif (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
        .wdata_i(bus_wdata_i), .st_i(st), .irq_i(irq_o), .arm_o(arm),
        .clr_o(clr), .rdata_o(bus_rdata_o)
    );

    // Request level follows the presence of any flag
    always_comb irq_o = |st;

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(hit) != '0));
    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(clr) != '0));
endmodule

// File: tb/line_event_irq_bench.sv
// Bench: directed corner cases, then seeded random traffic checked against a
// behavioural model built from the requirements.
module line_event_irq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NLINE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line = 32'h0000_00F0;
    logic [2:0]  addr = 3'd0;
    logic        wr = 1'b0;
    logic [7:0]  wd = 8'h00;
    logic [7:0]  rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Behavioural model state
    logic [31:0] m_st = '0, m_prev = '0;
    logic [7:0]  m_en = '0;

    line_event_irq u_line_event_irq (
        .clk(clk), .rst_n(rst_n), .line_i(line), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_wdata_i(wd), .bus_rdata_o(rdata), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model update at each rising edge from the driven inputs
    always @(posedge clk) begin
        logic [31:0] rmask, fmask, clrv, hitv;
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_prev = line;
        end else begin
            for (int b = 0; b < 4; b++) begin
                rmask[b*8 +: 8] = {8{m_en[b]}};
                fmask[b*8 +: 8] = {8{m_en[b+4]}};
            end
            hitv = (line & ~m_prev & rmask) | (~line & m_prev & fmask);
            clrv = '0;
            if (wr && addr < 3'd4) clrv = 32'(wd) << (8 * addr);
            m_st = (m_st & ~clrv) | hitv;
            if (wr && addr == 3'd4) m_en = wd;
            m_prev = line;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        if (a < 3'd4)  return m_st[a*8 +: 8];
        if (a == 3'd4) return m_en;
        if (a == 3'd5) return {7'b0, m_st != 0};
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge
    task automatic step(input logic [31:0] l, input logic w, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        line = l; wr = w; addr = a; wd = d;
    endtask

    // Read an address at the falling edge and compare with a literal
    task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        wr = 1'b0; addr = a;
        #1;
        check(tag, 32'(rdata), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] l;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        for (int a = 0; a < 6; a++) peek(3'(a), 8'h00, "R9 reset read");
        check("R9 irq after reset", 32'(irq), 32'd0);
        l = 32'h0000_00F0;
        step(l, 1'b1, 3'd4, 8'hFF);
        peek(3'd0, 8'h00, "R9 held level no flag");
        peek(3'd4, 8'hFF, "R10 arm readback");
        // R1 rising bank 0, R11 visible after one edge
        step(l, 1'b1, 3'd4, 8'h01);
        l = 32'h0000_00F8;
        step(l, 1'b0, 3'd0, 8'h00);
        @(negedge clk); #1;
        check("R11 flag one edge after change", 32'(irq), 32'd1);
        peek(3'd0, 8'h08, "R1 rising flag");
        peek(3'd5, 8'h01, "R8 pin readback high");
        // R2 falling unarmed, R4 sticky
        l = 32'h0000_00F0;
        step(l, 1'b0, 3'd0, 8'h00);
        peek(3'd0, 8'h08, "R4 sticky after return");
        // R5 clears
        step(l, 1'b1, 3'd0, 8'h00);
        peek(3'd0, 8'h08, "R5 zero write keeps");
        step(l, 1'b1, 3'd1, 8'hFF);
        peek(3'd0, 8'h08, "R5 other byte keeps");
        step(l, 1'b1, 3'd0, 8'h08);
        peek(3'd0, 8'h00, "R5 one clears");
        peek(3'd5, 8'h00, "R8 pin low");
        check("R8 irq low", 32'(irq), 32'd0);
        // R2 falling bank 1
        step(l, 1'b1, 3'd4, 8'h20);
        l = 32'h0000_FFF0;
        step(l, 1'b0, 3'd0, 8'h00);
        peek(3'd1, 8'h00, "R1 rising unarmed bank");
        l = 32'h0000_FDF0;
        step(l, 1'b0, 3'd0, 8'h00);
        peek(3'd1, 8'h02, "R2 falling flag");
        // R3 bank 3 mapping
        step(l, 1'b1, 3'd4, 8'h08);
        l = l | 32'h1000_0000;
        step(l, 1'b0, 3'd0, 8'h00);
        peek(3'd3, 8'h10, "R3 line 28 byte 3");
        peek(3'd1, 8'h02, "R3 bank 1 untouched");
        // R7 disarm keeps flags
        step(l, 1'b1, 3'd4, 8'h00);
        peek(3'd3, 8'h10, "R7 flag kept");
        peek(3'd1, 8'h02, "R7 flag kept bank 1");
        // R6 set wins over clear
        step(l, 1'b1, 3'd4, 8'h04);
        l = l | 32'h0001_0000;
        step(l, 1'b1, 3'd2, 8'h01);
        peek(3'd2, 8'h01, "R6 set wins");
        step(l, 1'b1, 3'd2, 8'h01);
        peek(3'd2, 8'h00, "R5 clear after race");
        step(l, 1'b1, 3'd1, 8'hFF);
        step(l, 1'b1, 3'd3, 8'hFF);
        @(negedge clk); #1;
        check("R8 irq low after all cleared", 32'(irq), 32'd0);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] flip;
            flip = '0;
            if ($urandom_range(0, 1) == 0) flip[$urandom_range(0, 31)] = 1'b1;
            if ($urandom_range(0, 3) == 0) flip[$urandom_range(0, 31)] = 1'b1;
            @(negedge clk);
            line = line ^ flip;
            wr = ($urandom_range(0, 9) < 3);
            addr = 3'($urandom_range(0, 7));
            wd = 8'($urandom);
            #1;
            check("R3 R5 R10 random read", 32'(rdata), 32'(exp_rd(addr)));
            check("R8 random irq", 32'(irq), 32'(m_st != 0));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule